// File: doc/BRIEF.md
# Programming Interface Session Sequencer

This controller opens and closes a programming session with a target device over a two-wire data/clock link. It supports two ways of getting into programming mode. In the clock-as-reset mode the target's clock pin also serves as its reset input. In the separate-reset mode a dedicated reset line is held low for the whole session. Byte framing and the bit-level shifting belong to a neighbouring frame engine. This block only asks that engine for idle (break) frames and for a change of direction, and waits for its answers.

A bring-up starts with a single-cycle `en_cmd`. In the clock-as-reset mode the sequencer takes the pins and drives the data line high for a brief window counted in system clocks. In the separate-reset mode it first drives reset low for a number of microsecond ticks and then parks data at its idle-high level. Both modes then request two break frames back to back and raise `ready`. A `dis_cmd` turns the engine back to receive and waits for it to go quiet. It then either holds the clock high for a timed restart or releases the data and clock pins before the reset line.

Top module: `sess_seq`

## Requirements
- R1: While and after reset, `ready`, `pin_en`, `dat_hi`, `clk_hi`, `rst_oe`, `brk_req` and `dir_tx` are all 0 and `rst_out` is 1.
- R2: In clock-as-reset mode (`mode_sel`=0 at the command), `pin_en` rises together with `dat_hi`. `dat_hi` stays high for exactly PULSE_CLKS system clocks, which is the smallest count covering PULSE_MIN_NS (23 at 250 MHz and 90 ns). `dir_tx` is 0 (receive) during this window.
- R3: After the pulse (or the idle-high cycle), exactly two single-cycle `brk_req` pulses are issued. The second one follows the first `brk_done`. `dir_tx` is 1 from the first request on.
- R4: `ready` rises in the cycle after the second `brk_done` is sampled, and never earlier.
- R5: In separate-reset mode (`mode_sel`=1), `rst_oe`=1 with `rst_out`=0 and `pin_en`=0 lasts for exactly RST_US microsecond ticks. Then `pin_en` rises with `dat_hi` high for one cycle. Reset stays driven low throughout the session.
- R6: `dis_cmd` while ready drops `ready` and `dir_tx` in the next cycle. The pins stay owned and unchanged until `eng_idle` is sampled high.
- R7: In clock-as-reset mode, take-down then holds `clk_hi`=1 with `pin_en`=1 for exactly HOLD_US microsecond ticks, after which `pin_en` and `clk_hi` fall together.
- R8: In separate-reset mode, take-down releases `pin_en` one cycle before `rst_oe` falls.
- R9: `en_cmd` outside the idle state and `dis_cmd` outside the ready state have no effect. The mode is latched when the session starts, so later changes of `mode_sel` have no effect on that session.
- R10: In clock-as-reset mode `rst_oe` is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_cmd | input | 1 | Single-cycle request to open a session |
| dis_cmd | input | 1 | Single-cycle request to close the session |
| mode_sel | input | 1 | 0 = clock-as-reset, 1 = separate reset line |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| brk_done | input | 1 | Frame engine finished the requested break frame |
| eng_idle | input | 1 | Frame engine has no transmission pending |
| ready | output | 1 | Session open, engine may exchange bytes |
| pin_en | output | 1 | Data and clock pins owned (1) or high impedance (0) |
| dat_hi | output | 1 | Force data pin high |
| clk_hi | output | 1 | Force clock pin high |
| rst_oe | output | 1 | Reset line output enable |
| rst_out | output | 1 | Reset line level when enabled |
| brk_req | output | 1 | Single-cycle request for one break frame |
| dir_tx | output | 1 | Engine direction: 1 transmit, 0 receive |

## Verification
On every cycle, the checker confirms several orderings: the session starts in receive direction, `ready` appears only right after a break completes and only with a clean pin state, the data-high window never outgrows its system-clock bound, a clock hold ends with the pins released, and the reset line is freed only after the data and clock pins. The exact window lengths counted in microsecond ticks, the number and order of break requests, the effect of the latched mode on take-down, and the ignoring of stray commands can only be shown by the bench's scenarios. The bench compares the observed sequence of pin events against the expected one.

// File: rtl/sess_pkg.sv
// Shared types for the programming-session sequencer.
// Assumes: one state register, decoded by sess_pins.
package sess_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_PULSE,
        ST_RSTLOW,
        ST_IDLEHI,
        ST_BRK_REQ,
        ST_BRK_WAIT,
        ST_READY,
        ST_DRAIN,
        ST_CLKHOLD,
        ST_REL
    } sess_state_t;

    typedef enum logic {
        MODE_CLKRST = 1'b0,
        MODE_SEPRST = 1'b1
    } sess_mode_t;

endpackage

// File: rtl/sess_timer.sv
// Interval counter shared by the timed phases of the sequencer.
// Counts step pulses from a clear; done fires on the step that
// completes 'limit' steps. Assumes limit >= 1.
module sess_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          done
);

    logic [CW-1:0] cnt_q;

    // Step counter, restarted on every phase change.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= '0;
        else if (step)
            cnt_q <= cnt_q + 1'b1;
    end

    // Completion of the programmed number of steps.
    always_comb begin
        done = step && (cnt_q == (limit - 1'b1));
    end

endmodule

// File: rtl/sess_pins.sv
// Decodes the sequencer state and latched mode into pin controls.
// Assumes the state register is the only source of pin behaviour.
module sess_pins
    import sess_pkg::*;
(
    input  sess_state_t state,
    input  sess_mode_t  mode,
    output logic        ready,
    output logic        pin_en,
    output logic        dat_hi,
    output logic        clk_hi,
    output logic        rst_oe,
    output logic        rst_out,
    output logic        brk_req,
    output logic        dir_tx
);

    // Pin ownership, forced levels and engine requests per state.
    always_comb begin
        ready   = (state == ST_READY);
        pin_en  = !((state == ST_IDLE) || (state == ST_RSTLOW) || (state == ST_REL));
        dat_hi  = (state == ST_PULSE) || (state == ST_IDLEHI);
        clk_hi  = (state == ST_CLKHOLD);
        rst_oe  = (mode == MODE_SEPRST) && (state != ST_IDLE);
        rst_out = !rst_oe;
        brk_req = (state == ST_BRK_REQ);
        dir_tx  = (state == ST_BRK_REQ) || (state == ST_BRK_WAIT) || (state == ST_READY);
    end

endmodule

// File: rtl/sess_seq.sv
// Programming-session sequencer: opens and closes a target session
// in clock-as-reset or separate-reset mode. Assumes us_tick is a
// single-cycle strobe and the frame engine answers each brk_req with
// one brk_done pulse. Commands outside their legal state are dropped.
module sess_seq
    import sess_pkg::*;
#(
    parameter int CLK_MHZ      = 250,
    parameter int PULSE_MIN_NS = 90,
    parameter int RST_US       = 1000,
    parameter int HOLD_US      = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_cmd,
    input  logic dis_cmd,
    input  logic mode_sel,
    input  logic us_tick,
    input  logic brk_done,
    input  logic eng_idle,
    output logic ready,
    output logic pin_en,
    output logic dat_hi,
    output logic clk_hi,
    output logic rst_oe,
    output logic rst_out,
    output logic brk_req,
    output logic dir_tx
);

    localparam int PULSE_RAW  = (PULSE_MIN_NS * CLK_MHZ + 999) / 1000;
    localparam int PULSE_CLKS = (PULSE_RAW < 1) ? 1 : PULSE_RAW;
    localparam int MAX_A      = (RST_US > HOLD_US) ? RST_US : HOLD_US;
    localparam int MAX_V      = (MAX_A > PULSE_CLKS) ? MAX_A : PULSE_CLKS;
    localparam int CW         = $clog2(MAX_V + 1);

    sess_state_t   state_q, state_n;
    sess_mode_t    mode_q;
    logic          second_q;
    logic          tmr_clr, tmr_step, tmr_done;
    logic [CW-1:0] tmr_limit;

    // Timer source and length for the current timed phase.
    always_comb begin
        tmr_step  = 1'b0;
        tmr_limit = CW'(1);
        case (state_q)
            ST_PULSE: begin
                tmr_step  = 1'b1;
                tmr_limit = CW'(PULSE_CLKS);
            end
            ST_RSTLOW: begin
                tmr_step  = us_tick;
                tmr_limit = CW'(RST_US);
            end
            ST_CLKHOLD: begin
                tmr_step  = us_tick;
                tmr_limit = CW'(HOLD_US);
            end
            default: ;
        endcase
    end

    // Session sequencing: bring-up, steady state, take-down.
    always_comb begin
        state_n = state_q;
        case (state_q)
            ST_IDLE:     if (en_cmd) state_n = mode_sel ? ST_RSTLOW : ST_PULSE;
            ST_PULSE:    if (tmr_done) state_n = ST_BRK_REQ;
            ST_RSTLOW:   if (tmr_done) state_n = ST_IDLEHI;
            ST_IDLEHI:   state_n = ST_BRK_REQ;
            ST_BRK_REQ:  state_n = ST_BRK_WAIT;
            ST_BRK_WAIT: if (brk_done) state_n = second_q ? ST_READY : ST_BRK_REQ;
            ST_READY:    if (dis_cmd) state_n = ST_DRAIN;
            ST_DRAIN:    if (eng_idle) state_n = (mode_q == MODE_SEPRST) ? ST_REL : ST_CLKHOLD;
            ST_CLKHOLD:  if (tmr_done) state_n = ST_IDLE;
            ST_REL:      state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
        tmr_clr = (state_n != state_q);
    end

    // State, latched mode and break-count registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            mode_q   <= MODE_CLKRST;
            second_q <= 1'b0;
        end else begin
            state_q <= state_n;
            if (state_q == ST_IDLE) begin
                second_q <= 1'b0;
                if (en_cmd)
                    mode_q <= sess_mode_t'(mode_sel);
            end else if (state_q == ST_BRK_WAIT && brk_done) begin
                second_q <= 1'b1;
            end
        end
    end

    sess_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .step  (tmr_step),
        .limit (tmr_limit),
        .done  (tmr_done)
    );

    sess_pins u_pins (
        .state   (state_q),
        .mode    (mode_q),
        .ready   (ready),
        .pin_en  (pin_en),
        .dat_hi  (dat_hi),
        .clk_hi  (clk_hi),
        .rst_oe  (rst_oe),
        .rst_out (rst_out),
        .brk_req (brk_req),
        .dir_tx  (dir_tx)
    );

endmodule

// File: rtl/sess_seq_chk.sv
// Cycle-by-cycle properties of the session sequencer, bound to the top.
// Assumes the same parameters as the bound instance.
module sess_seq_chk #(
    parameter int CLK_MHZ      = 250,
    parameter int PULSE_MIN_NS = 90
) (
    input logic clk,
    input logic rst_n,
    input logic en_cmd,
    input logic dis_cmd,
    input logic brk_done,
    input logic ready,
    input logic pin_en,
    input logic dat_hi,
    input logic clk_hi,
    input logic rst_oe,
    input logic brk_req,
    input logic dir_tx
);

    localparam int PULSE_RAW  = (PULSE_MIN_NS * CLK_MHZ + 999) / 1000;
    localparam int PULSE_CLKS = (PULSE_RAW < 1) ? 1 : PULSE_RAW;

    int unsigned hi_run;

    // Length of the current data-high run in completed cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_run <= 0;
        else
            hi_run <= dat_hi ? hi_run + 1 : 0;
    end

    AST_PULSE_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        dat_hi |-> (hi_run < PULSE_CLKS)); // R2

    AST_SESSION_STARTS_RX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pin_en) |-> !dir_tx); // R2

    AST_BREAK_IN_TX: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> (dir_tx && !ready)); // R3

    AST_READY_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> $past(brk_done)); // R4

    AST_READY_CLEAN_PINS: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (pin_en && dir_tx && !dat_hi && !clk_hi)); // R4

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && dis_cmd) |=> (!ready && !dir_tx && pin_en)); // R6

    AST_HOLD_THEN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(clk_hi) |-> !pin_en); // R7

    AST_RESET_FREED_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_oe) |-> $past(!pin_en)); // R8

    AST_EN_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && en_cmd && !dis_cmd) |=> ready); // R9

    AST_HOLD_NO_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        clk_hi |-> !rst_oe); // R10

endmodule

bind sess_seq sess_seq_chk #(
    .CLK_MHZ      (CLK_MHZ),
    .PULSE_MIN_NS (PULSE_MIN_NS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_cmd   (en_cmd),
    .dis_cmd  (dis_cmd),
    .brk_done (brk_done),
    .ready    (ready),
    .pin_en   (pin_en),
    .dat_hi   (dat_hi),
    .clk_hi   (clk_hi),
    .rst_oe   (rst_oe),
    .brk_req  (brk_req),
    .dir_tx   (dir_tx)
);

// File: tb/sess_seq_test.sv
// Scoreboard bench: scenarios push expected pin events, a monitor
// detects events at the ports and compares them in order.
module sess_seq_test;

    localparam int RST_T  = 5;
    localparam int HOLD_T = 4;
    localparam int PULSE  = 23;

    localparam int EV_PINEN  = 0;
    localparam int EV_RSTOE  = 1;
    localparam int EV_RSTLOW = 2;
    localparam int EV_DATHI  = 3;
    localparam int EV_DIR    = 4;
    localparam int EV_BRK    = 5;
    localparam int EV_READY  = 6;
    localparam int EV_HOLD   = 7;

    typedef struct {
        int    kind;
        int    val;
        string req;
    } ev_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en_cmd = 1'b0, dis_cmd = 1'b0, mode_sel = 1'b0;
    logic us_tick = 1'b0, brk_done = 1'b0, eng_idle = 1'b0;
    logic ready, pin_en, dat_hi, clk_hi, rst_oe, rst_out, brk_req, dir_tx;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;
    ev_t exp_q[$];

    always #2 clk = ~clk;

    sess_seq #(.RST_US(RST_T), .HOLD_US(HOLD_T)) uut (
        .clk(clk), .rst_n(rst_n), .en_cmd(en_cmd), .dis_cmd(dis_cmd),
        .mode_sel(mode_sel), .us_tick(us_tick), .brk_done(brk_done),
        .eng_idle(eng_idle), .ready(ready), .pin_en(pin_en), .dat_hi(dat_hi),
        .clk_hi(clk_hi), .rst_oe(rst_oe), .rst_out(rst_out),
        .brk_req(brk_req), .dir_tx(dir_tx)
    );

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic expect_ev(input int kind, input int val, input string req);
        ev_t e;
        e.kind = kind; e.val = val; e.req = req;
        exp_q.push_back(e);
    endtask

    task automatic emit(input int kind, input int val);
        ev_t e;
        checks++;
        if (exp_q.size() == 0) begin
            fails++;
            $display("FAIL R9 unexpected event actual=%0d/%0d expected=none", kind, val);
        end else begin
            e = exp_q.pop_front();
            if (e.kind != kind || e.val != val) begin
                fails++;
                $display("FAIL %s event actual=%0d/%0d expected=%0d/%0d",
                         e.req, kind, val, e.kind, e.val);
            end
        end
    endtask

    // Microsecond strobe every third cycle.
    initial begin
        forever begin
            repeat (2) @(posedge clk);
            #1 us_tick = 1'b1;
            @(posedge clk);
            #1 us_tick = 1'b0;
        end
    end

    // Frame engine model: answers a break, goes idle after receive turn.
    initial begin
        forever begin
            @(negedge clk);
            if (brk_req) begin
                repeat (4) @(posedge clk);
                #1 brk_done = 1'b1;
                @(posedge clk);
                #1 brk_done = 1'b0;
            end
        end
    end

    initial begin
        int quiet = 0;
        forever begin
            @(posedge clk);
            #1;
            if (dir_tx) begin
                quiet = 0;
                eng_idle = 1'b0;
            end else if (quiet < 6) begin
                quiet++;
                eng_idle = 1'b0;
            end else begin
                eng_idle = 1'b1;
            end
        end
    end

    // Monitor: turns port activity into events for the scoreboard.
    bit p_pin, p_rst, p_rl, p_dat, p_dir, p_rdy, p_clk;
    int rl_ticks, dat_run, hold_ticks;
    always @(negedge clk) begin
        bit in_rl;
        if (!rst_n) begin
            p_pin = 0; p_rst = 0; p_rl = 0; p_dat = 0; p_dir = 0; p_rdy = 0; p_clk = 0;
            rl_ticks = 0; dat_run = 0; hold_ticks = 0;
        end else begin
            in_rl = rst_oe && !rst_out && !pin_en;
            if (pin_en != p_pin) emit(EV_PINEN, int'(pin_en));
            if (rst_oe != p_rst) emit(EV_RSTOE, int'(rst_oe));
            if (p_rl && !in_rl && pin_en) emit(EV_RSTLOW, rl_ticks);
            if (p_dat && !dat_hi) emit(EV_DATHI, dat_run);
            if (dir_tx != p_dir) emit(EV_DIR, int'(dir_tx));
            if (brk_req) emit(EV_BRK, 0);
            if (ready != p_rdy) emit(EV_READY, int'(ready));
            if (p_clk && !clk_hi) emit(EV_HOLD, hold_ticks);
            if (in_rl) rl_ticks = (p_rl ? rl_ticks : 0) + int'(us_tick);
            if (dat_hi) dat_run = (p_dat ? dat_run : 0) + 1;
            if (clk_hi) hold_ticks = (p_clk ? hold_ticks : 0) + int'(us_tick);
            p_pin = pin_en; p_rst = rst_oe; p_rl = in_rl; p_dat = dat_hi;
            p_dir = dir_tx; p_rdy = ready; p_clk = clk_hi;
        end
    end

    task automatic pulse_en();
        @(posedge clk); #1 en_cmd = 1'b1;
        @(posedge clk); #1 en_cmd = 1'b0;
    endtask

    task automatic pulse_dis();
        @(posedge clk); #1 dis_cmd = 1'b1;
        @(posedge clk); #1 dis_cmd = 1'b0;
    endtask

    task automatic wait_drain();
        while (exp_q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(!ready && !pin_en && !dat_hi && !clk_hi && !rst_oe && rst_out && !brk_req && !dir_tx,
              "R1 reset outputs", int'({ready, pin_en, rst_oe, dir_tx}), 0);
        @(posedge clk); #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(!pin_en && !rst_oe && rst_out, "R1 after release", int'(pin_en), 0);

        // Clock-as-reset session; a second enable during the pulse is dropped.
        mode_sel = 1'b0;
        expect_ev(EV_PINEN, 1, "R2 pins taken");
        expect_ev(EV_DATHI, PULSE, "R2 pulse length");
        expect_ev(EV_DIR, 1, "R3 tx on break");
        expect_ev(EV_BRK, 0, "R3 first break");
        expect_ev(EV_BRK, 0, "R3 second break");
        expect_ev(EV_READY, 1, "R4 ready");
        pulse_en();
        repeat (3) @(negedge clk);
        check(dat_hi && !dir_tx, "R2 receive during pulse", int'(dir_tx), 0);
        pulse_en();
        wait_drain();
        check(ready == 1'b1, "R4 ready held", int'(ready), 1);
        check(rst_oe == 1'b0, "R10 no reset drive", int'(rst_oe), 0);

        // Enable while ready, and a mode change, have no effect.
        mode_sel = 1'b1;
        pulse_en();
        repeat (3) @(negedge clk);
        check(ready && pin_en, "R9 enable ignored when ready", int'(ready), 1);

        expect_ev(EV_DIR, 0, "R6 turn to receive");
        expect_ev(EV_READY, 0, "R6 ready drop");
        expect_ev(EV_PINEN, 0, "R7 pins released");
        expect_ev(EV_HOLD, HOLD_T, "R7 hold length");
        pulse_dis();
        repeat (2) @(negedge clk);
        check(pin_en && !clk_hi && !ready, "R6 waits for engine", int'(clk_hi), 0);
        wait_drain();
        check(!pin_en && !rst_oe, "R7 high impedance", int'(pin_en), 0);

        // Disable while idle has no effect.
        pulse_dis();
        repeat (4) @(negedge clk);
        check(!pin_en && !ready && !rst_oe, "R9 disable ignored when idle", int'(pin_en), 0);

        // Separate-reset session.
        mode_sel = 1'b1;
        expect_ev(EV_RSTOE, 1, "R5 reset driven");
        expect_ev(EV_PINEN, 1, "R5 pins taken");
        expect_ev(EV_RSTLOW, RST_T, "R5 reset-low length");
        expect_ev(EV_DATHI, 1, "R5 idle-high cycle");
        expect_ev(EV_DIR, 1, "R3 tx on break");
        expect_ev(EV_BRK, 0, "R3 first break");
        expect_ev(EV_BRK, 0, "R3 second break");
        expect_ev(EV_READY, 1, "R4 ready");
        pulse_en();
        wait_drain();
        check(ready && rst_oe && !rst_out, "R5 reset held low in session", int'(rst_out), 0);

        mode_sel = 1'b0;
        expect_ev(EV_DIR, 0, "R6 turn to receive");
        expect_ev(EV_READY, 0, "R6 ready drop");
        expect_ev(EV_PINEN, 0, "R8 pins released first");
        expect_ev(EV_RSTOE, 0, "R8 reset released last");
        pulse_dis();
        wait_drain();
        check(!rst_oe && rst_out && !pin_en, "R8 all released", int'(rst_oe), 0);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R3 scoreboard empty", exp_q.size(), 0);
        finish_run();
    end

endmodule